// File: doc/BRIEF.md
# Transition-Only Sample Recorder

This block is the storage stage of a timing-mode capture path. Once armed, it samples a parallel channel bus on every edge of its own clock. It keeps a sample only when the sample differs from the last level it stored. Each kept sample costs two memory words: a time stamp taken from a free-running counter, then the new channel value. Stretches with no activity therefore use no memory, and the time span a capture covers depends on how busy the signals are.

Capture stops by itself once the memory cannot hold another complete pair. Readout logic picks a pair by index, oldest first, and gets the time stamp, a wrap flag and the channel value back in the same cycle. A pair count output tells the readout logic how many pairs are valid. Whenever the time-stamp counter is about to roll over, the block stores a pair with the wrap flag set. This lets the reader rebuild absolute time across any number of wraps.

Top module: `transition_recorder`

## Requirements
- R1: A one-cycle `arm` pulse clears the stored pairs and the time stamp. `busy` is high from the next cycle, and `pair_cnt` reads 0 until the first write.
- R2: While `busy`, a sample equal to the last stored value writes nothing. A sample that differs in any channel writes one pair.
- R3: The first sample after arming is always stored, with time stamp 0 and the current channel value.
- R4: Pair k (k = 0 is the oldest) sits in word 2k, holding {wrap flag, time stamp}, and in word 2k+1, holding the value. Setting `rd_idx` = k returns `rd_time`, `rd_wrap` and `rd_value` combinationally. The time stamp counts capture cycles from 0 at the first sample, modulo 2^TS_W.
- R5: On a capture cycle whose time stamp is all ones, a pair is written with `rd_wrap` = 1 and the current value, whether or not the input changed. Every other pair has `rd_wrap` = 0.
- R6: `full` goes high when fewer than two free words remain, which is after floor(DEPTH/2) pairs. `busy` then drops, and no further word is written while `full` holds.
- R7: `pair_cnt` equals the number of complete pairs stored since the last arm.
- R8: After reset, `busy` = 0, `full` = 0 and `pair_cnt` = 0.
- R9: While not `busy`, input activity stores nothing.
- R10: Arming during a capture restarts it. The count returns to 0, and the next stored pair has time stamp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Start (or restart) a capture |
| chan_in | input | CH_W | Channel bus being sampled |
| busy | output | 1 | Capture is running |
| full | output | 1 | No room for another pair |
| pair_cnt | output | CNT_W | Number of complete pairs stored |
| rd_idx | input | IDX_W | Pair index to read |
| rd_time | output | TS_W | Time stamp of the selected pair |
| rd_wrap | output | 1 | Selected pair marks a counter wrap |
| rd_value | output | CH_W | Channel value of the selected pair |

## Verification
The input is held steady for several cycles, which separates discarding from storing. It is then changed in one bit and in all bits at once, which shows that every channel takes part in the comparison. A hold longer than the counter period must yield exactly one wrap-flagged pair at time stamp 31 and nothing else. An input that toggles every cycle fills the memory at full rate, with an odd depth, and so checks the stopping point and that no half pair is written. Re-arming in mid-stream shows that the count and the time base restart together.

// File: rtl/tsr_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the transition recorder.
// Assumes nothing beyond standard elaboration.
package tsr_pkg;

    // Capture control state.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Larger of two integers, used to size memory words.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tsr_stamp_counter.sv
`timescale 1ns/1ps
// Module: tsr_stamp_counter
// Free-running time-stamp counter. It counts capture cycles and wraps
// modulo 2^TS_W. `clr` restarts it at 0. `at_top` flags the all-ones
// value, which is the last count before the wrap.
// Assumes clr and run are never both meant to advance the count.
module tsr_stamp_counter #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    output logic [TS_W-1:0] ts,
    output logic            at_top
);

    logic [TS_W-1:0] ts_q;

    // Count one per capture cycle; clear on arm or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ts_q <= '0;
        end else if (run) begin
            ts_q <= ts_q + 1'b1;
        end
    end

    assign ts     = ts_q;
    assign at_top = &ts_q;

    AST_TS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (ts_q == TS_W'($past(ts_q) + 1'b1)));   // R4
    AST_TS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ts_q == '0));                                    // R10

endmodule

// File: rtl/tsr_change_detect.sv
`timescale 1ns/1ps
// Module: tsr_change_detect
// Compares each capture sample with the last stored level. It requests
// a store on the first sample after clear, on any channel difference,
// or when the time-stamp counter is at its top value (forced marker).
// Assumes `run` is already gated by free space and by arm.
module tsr_change_detect #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic [CH_W-1:0] sample,
    input  logic            force_top,
    output logic            store,
    output logic            wrap
);

    logic [CH_W-1:0] last_q;
    logic            first_q;
    logic            differs;

    // Any channel differing from the held level counts as a change.
    always_comb begin
        differs = (sample != last_q);
    end

    assign store = run && (first_q || differs || force_top);
    assign wrap  = run && force_top;

    // Track whether the next capture sample is the first after arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (clr) begin
            first_q <= 1'b1;
        end else if (run) begin
            first_q <= 1'b0;
        end
    end

    // Hold the most recently stored channel value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (store) begin
            last_q <= sample;
        end
    end

    AST_FIRST_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && first_q) |-> store);                              // R3
    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (last_q == $past(sample)));                     // R2

endmodule

// File: rtl/tsr_pair_store.sv
`timescale 1ns/1ps
// Module: tsr_pair_store
// Word-addressed capture memory written two words per event: the time
// word {wrap, stamp} at 2k and the value word at 2k+1. It keeps the
// count of complete pairs and raises `full` when fewer than two words
// are free. A combinational read port returns pair `rd_idx`.
// Assumes wr_en is never raised while full (checked below).
module tsr_pair_store #(
    parameter int CH_W  = 8,
    parameter int TS_W  = 16,
    parameter int DEPTH = 64,
    localparam int PAIRS = DEPTH / 2,
    localparam int CNT_W = $clog2(PAIRS + 1),
    localparam int IDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [TS_W-1:0]  wr_time,
    input  logic             wr_wrap,
    input  logic [CH_W-1:0]  wr_value,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TS_W-1:0]  rd_time,
    output logic             rd_wrap,
    output logic [CH_W-1:0]  rd_value,
    output logic [CNT_W-1:0] pair_cnt,
    output logic             full
);

    localparam int MW = tsr_pkg::max_int(TS_W + 1, CH_W);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [MW-1:0]    mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    wa_time, wa_value;
    logic [AW-1:0]    ra_time, ra_value;
    logic [MW-1:0]    time_word, value_word;
    logic             rd_ok;

    assign full = (int'(cnt_q) >= PAIRS);

    // Word addresses of the pair being written.
    always_comb begin
        wa_time    = AW'({cnt_q, 1'b0});
        wa_value   = AW'({cnt_q, 1'b1});
        time_word  = MW'({wr_wrap, wr_time});
        value_word = MW'(wr_value);
    end

    // One write slot per memory word; the pair lands in two words at once.
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && (wa_time == AW'(w))) begin
                mem[w] <= time_word;
            end else if (wr_en && (wa_value == AW'(w))) begin
                mem[w] <= value_word;
            end
        end
    end

    // Count complete pairs; restart on arm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (wr_en && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Combinational readout of pair rd_idx.
    always_comb begin
        ra_time  = AW'({rd_idx, 1'b0});
        ra_value = AW'({rd_idx, 1'b1});
        rd_ok    = (int'(rd_idx) < PAIRS);
        rd_time  = rd_ok ? mem[ra_time][TS_W-1:0] : '0;
        rd_wrap  = rd_ok ? mem[ra_time][TS_W]     : 1'b0;
        rd_value = rd_ok ? mem[ra_value][CH_W-1:0] : '0;
    end

    assign pair_cnt = cnt_q;

    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);                                         // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R7
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(cnt_q));                     // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= PAIRS);                                    // R6

endmodule

// File: rtl/transition_recorder.sv
`timescale 1ns/1ps
// Module: transition_recorder (top)
// Timing-mode storage compressor. Once armed, it samples chan_in every
// clock and stores a (time stamp, value) pair only on a change, on the
// first sample, or at a time-stamp wrap. It stops when memory is full.
// Assumes arm is a pulse synchronous to clk; arm beats capture in the
// same cycle.
module transition_recorder
    import tsr_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int TS_W  = 16,
    parameter int DEPTH = 64,
    localparam int PAIRS = DEPTH / 2,
    localparam int CNT_W = $clog2(PAIRS + 1),
    localparam int IDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CH_W-1:0]  chan_in,
    output logic             busy,
    output logic             full,
    output logic [CNT_W-1:0] pair_cnt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TS_W-1:0]  rd_time,
    output logic             rd_wrap,
    output logic [CH_W-1:0]  rd_value
);

    run_state_e      st_q;
    logic            run;
    logic [TS_W-1:0] ts;
    logic            at_top;
    logic            wr_en;
    logic            wr_wrap;

    // Capture control: arm starts, a full memory ends the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (arm) begin
            st_q <= ST_RUN;
        end else if ((st_q == ST_RUN) && full) begin
            st_q <= ST_IDLE;
        end
    end

    assign busy = (st_q == ST_RUN) && !full;
    assign run  = busy && !arm;

    tsr_stamp_counter #(.TS_W(TS_W)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (arm),
        .run    (run),
        .ts     (ts),
        .at_top (at_top)
    );

    tsr_change_detect #(.CH_W(CH_W)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (arm),
        .run       (run),
        .sample    (chan_in),
        .force_top (at_top),
        .store     (wr_en),
        .wrap      (wr_wrap)
    );

    tsr_pair_store #(.CH_W(CH_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (arm),
        .wr_en    (wr_en),
        .wr_time  (ts),
        .wr_wrap  (wr_wrap),
        .wr_value (chan_in),
        .rd_idx   (rd_idx),
        .rd_time  (rd_time),
        .rd_wrap  (rd_wrap),
        .rd_value (rd_value),
        .pair_cnt (pair_cnt),
        .full     (full)
    );

    AST_ARM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (pair_cnt == '0));                                // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);                                        // R9
    AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wrap) |-> (ts == '1));                       // R5

endmodule

// File: tb/transition_recorder_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models each capture cycle and queues the
// expected pairs; the monitor pops them as pair_cnt advances.
module transition_recorder_bench;

    localparam int CH_W  = 8;
    localparam int TS_W  = 5;
    localparam int DEPTH = 21;
    localparam int PAIRS = DEPTH / 2;
    localparam int CNT_W = $clog2(PAIRS + 1);
    localparam int IDX_W = $clog2(PAIRS);
    localparam int TMAX  = (1 << TS_W) - 1;

    typedef struct {
        int t;
        bit w;
        int v;
        bit first;
    } pair_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic [CH_W-1:0]  chan_in = '0;
    logic             busy, full, rd_wrap;
    logic [CNT_W-1:0] pair_cnt;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [TS_W-1:0]  rd_time;
    logic [CH_W-1:0]  rd_value;

    int    checks = 0;
    int    failures = 0;
    pair_t exp_q[$];
    int    seen = 0;
    bit    done = 0;

    bit m_busy = 0, m_first = 0;
    int m_t = 0, m_last = 0, m_cnt = 0;

    always #4 clk = ~clk;

    transition_recorder #(.CH_W(CH_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_transition_recorder (
        .clk(clk), .rst_n(rst_n), .arm(arm), .chan_in(chan_in),
        .busy(busy), .full(full), .pair_cnt(pair_cnt), .rd_idx(rd_idx),
        .rd_time(rd_time), .rd_wrap(rd_wrap), .rd_value(rd_value)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: set inputs for the next edge and model that edge.
    task automatic cycle(input bit a, input int v);
        @(negedge clk);
        arm = a;
        chan_in = CH_W'(v);
        if (a) begin
            m_busy = 1; m_first = 1; m_t = 0; m_cnt = 0;
            exp_q.delete();
        end else if (m_busy) begin
            if (m_first || v != m_last || m_t == TMAX) begin
                exp_q.push_back('{t: m_t, w: (m_t == TMAX), v: v, first: m_first});
                m_cnt++;
                m_last = v;
                if (m_cnt == PAIRS) m_busy = 0;
            end
            m_first = 0;
            m_t = (m_t + 1) % (TMAX + 1);
        end
    endtask

    // Monitor: compare each newly completed pair with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (int'(pair_cnt) < seen) seen = 0;
            while (seen < int'(pair_cnt)) begin
                pair_t e;
                rd_idx = IDX_W'(seen);
                #1;
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected pair", seen, -1);
                end else begin
                    e = exp_q.pop_front();
                    if (e.first) begin
                        chk(int'(rd_time) == 0, "R3 first time", int'(rd_time), 0);
                        chk(int'(rd_value) == e.v, "R3 first value", int'(rd_value), e.v);
                    end else if (e.w) begin
                        chk(rd_wrap == 1'b1, "R5 wrap flag", int'(rd_wrap), 1);
                        chk(int'(rd_value) == e.v, "R5 wrap value", int'(rd_value), e.v);
                    end else begin
                        chk(int'(rd_value) == e.v, "R2 change value", int'(rd_value), e.v);
                    end
                    chk(int'(rd_time) == e.t, "R4 time stamp", int'(rd_time), e.t);
                    chk(rd_wrap == e.w, "R4 wrap bit", int'(rd_wrap), int'(e.w));
                end
                seen++;
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R8 busy", int'(busy), 0);
        chk(full == 0, "R8 full", int'(full), 0);
        chk(pair_cnt == 0, "R8 pair_cnt", int'(pair_cnt), 0);

        // Idle activity must store nothing.
        for (int i = 0; i < 6; i++) cycle(0, i * 37);
        cycle(0, 0);
        chk(pair_cnt == 0, "R9 idle pair_cnt", int'(pair_cnt), 0);
        chk(busy == 0, "R9 idle busy", int'(busy), 0);

        // Arm, then steady, single-bit and all-bit changes.
        cycle(1, 8'h3C);
        cycle(0, 8'h3C);
        chk(busy == 1, "R1 busy after arm", int'(busy), 1);
        chk(pair_cnt == 0, "R1 count after arm", int'(pair_cnt), 0);
        cycle(0, 8'h3C); cycle(0, 8'h3C);
        cycle(0, 8'h3D); cycle(0, 8'h3D);
        cycle(0, 8'hC2); cycle(0, 8'hC2); cycle(0, 8'hC2);
        cycle(0, 8'h00);
        cycle(0, 8'h00);
        cycle(0, 8'h00);
        chk(int'(pair_cnt) == 4, "R7 pairs after changes", int'(pair_cnt), 4);
        chk(int'(pair_cnt) == m_cnt, "R2 steady stores nothing", int'(pair_cnt), m_cnt);

        // Long hold crosses the counter top: exactly one wrap pair.
        for (int i = 0; i < 36; i++) cycle(0, 8'h00);
        cycle(0, 8'h00);
        chk(int'(pair_cnt) == 5, "R5 single wrap pair", int'(pair_cnt), 5);
        chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);

        // Restart mid-capture.
        cycle(1, 8'h55);
        cycle(0, 8'h55);
        chk(pair_cnt == 0, "R10 count restarted", int'(pair_cnt), 0);
        chk(busy == 1, "R10 busy after rearm", int'(busy), 1);
        cycle(0, 8'h55);
        cycle(0, 8'h55);
        chk(int'(pair_cnt) == 1, "R10 first pair again", int'(pair_cnt), 1);

        // Toggle every cycle until full (odd depth).
        for (int i = 0; i < 20; i++) cycle(0, (i % 2 == 0) ? 8'hAA : 8'h55);
        cycle(0, 8'h0F);
        cycle(0, 8'h0F);
        chk(full == 1, "R6 full", int'(full), 1);
        chk(busy == 0, "R6 busy dropped", int'(busy), 0);
        chk(int'(pair_cnt) == PAIRS, "R6 pair limit", int'(pair_cnt), PAIRS);
        for (int i = 0; i < 5; i++) cycle(0, i + 1);
        cycle(0, 0);
        chk(int'(pair_cnt) == PAIRS, "R6 no write when full", int'(pair_cnt), PAIRS);
        chk(exp_q.size() == 0, "R7 all pairs seen", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule